// File: doc/BRIEF.md
# Register-Programmed Countdown Timer

This block is a per-core countdown timer that software controls through four small registers. One configuration word holds the arm bit, the auto-reload bit and the start count. When software writes a configuration value with the arm bit set, the counter loads at once. It then counts down by one on every cycle in which the tick strobe is high. When it runs out, it raises a level interrupt. In auto-reload mode the counter restarts from the programmed count. In single-shot mode the hardware clears the arm bit itself.

Software can read the ticks that remain and the fixed timer identity. It drops the interrupt by writing the acknowledge register. Access happens one request per cycle. A request is a plain read, a plain write, or a masked exchange that merges new bits under a mask and returns the previous value. The read data is registered and appears on the cycle after the request. It always shows the state before that request takes effect. The tick strobe stands for a nominal 100 MHz timebase, one tick per 10 ns.

Top module: `cdt_top`

## Requirements
- R1: After reset the configuration and the remaining count read 0 and the interrupt is low. The identity register (address 3) reads the parameter CORE_ID.
- R2: Register addresses are: configuration 0, remaining 1, acknowledge 2, identity 3. Request codes are: read 0, write 1, exchange 2. The configuration keeps bits 47:0 of the written value, and bits 63:48 read as 0. Bit 0 is the arm bit. If the new value has bit 0 set, the counter loads at once with bits 47:2 of the value, with its two low bits at zero.
- R3: While armed, the count drops by one on each tick. A loaded count N expires on tick N+1, so a count of 0 expires on the next tick.
- R4: Every expiry drives irq_o high from the following cycle, and it stays high until acknowledged.
- R5: With bit 1 (auto-reload) set, an expiry reloads the count field and the countdown continues.
- R6: With bit 1 clear, an expiry clears bit 0 of the configuration. The count then stays at 0 and no further expiry occurs.
- R7: A configuration write with bit 0 clear freezes the remaining count and leaves irq_o unchanged.
- R8: Any write or exchange to the acknowledge register drops irq_o. That register reads 0. An expiry in the same cycle as an acknowledge wins, and irq_o stays high.
- R9: An exchange to the configuration stores (old & ~mask) | (new & mask), arms as a write would, and returns the old value.
- R10: Reading the remaining register returns the live count. rsp_rdata shows the addressed register as it was before the request, one cycle after the request.
- R11: Writes to the remaining and identity registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe, one per tick |
| req_valid | input | 1 | Register request this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 exchange |
| req_addr | input | 2 | Register select |
| req_wdata | input | 64 | Write data |
| req_mask | input | 64 | Exchange mask |
| rsp_rdata | output | 64 | Registered read data |
| irq_o | output | 1 | Level timer interrupt |

## Verification
The hardest case to reach from the ports is an expiry that lands in the same cycle as an interrupt acknowledge. To reach it, the bench loads a count of zero in single-shot mode. It then raises the tick strobe and issues the acknowledge write in the same clock cycle, so expiry and clear meet at one edge. Auto-reload continuity is the other delicate case. The bench runs two full periods and compares the count after each one.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_XCHG = 2'd2
  } cdt_op_e;

  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_REM = 2'd1;
  localparam logic [1:0] A_ACK = 2'd2;
  localparam logic [1:0] A_ID  = 2'd3;
endpackage

// File: rtl/cdt_cfg_reg.sv
module cdt_cfg_reg #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              xchg,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mask,
  input  logic              expire,
  output logic [CNT_W-1:0]  cfg_q,
  output logic              arm,
  output logic [CNT_W-1:0]  arm_val
);
  logic [DATA_W-1:0] old_ext;
  logic [DATA_W-1:0] merged;
  logic [CNT_W-1:0]  new_cfg;

  always_comb begin
    old_ext = DATA_W'(cfg_q);
    merged  = xchg ? ((old_ext & ~mask) | (wdata & mask)) : wdata;
    new_cfg = merged[CNT_W-1:0];
    arm     = wr_en && new_cfg[0];
    arm_val = {new_cfg[CNT_W-1:2], 2'b00};
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (wr_en)
      cfg_q <= new_cfg;
    else if (expire && !cfg_q[1])
      cfg_q[0] <= 1'b0;
  end

  p_oneshot_disarm_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && !cfg_q[1]) |=> !cfg_q[0]);
  p_periodic_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (expire && cfg_q[1]) |=> cfg_q[0]);
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cfg_wr,
  input  logic             arm,
  input  logic [CNT_W-1:0] arm_val,
  input  logic             run,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;

  always_comb begin
    step   = !cfg_wr && run && tick;
    expire = step && (count == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (arm)
      count <= arm_val;
    else if (step) begin
      if (count == '0) begin
        if (periodic) count <= reload;
      end else begin
        count <= count - CNT_W'(1);
      end
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    arm |=> count == $past(arm_val));
  p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
    (step && count != '0) |=> count == $past(count) - CNT_W'(1));
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (expire && periodic) |=> count == $past(reload));
  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (!run && !cfg_wr) |=> $stable(count));
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)      irq_q <= 1'b0;
    else if (set) irq_q <= 1'b1;
    else if (clr) irq_q <= 1'b0;
  end

  p_irq_set_r4: assert property (@(posedge clk) disable iff (rst)
    set |=> irq_q);
  p_irq_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!set && !clr) |=> $stable(irq_q));
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !irq_q);
endmodule

// File: rtl/cdt_top.sv
module cdt_top #(
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 48,
  parameter int CORE_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_mask,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_o
);
  import cdt_pkg::*;

  localparam logic [DATA_W-1:0] ID_VAL = DATA_W'(CORE_ID);

  cdt_op_e          op;
  logic             is_wr;
  logic             cfg_wr;
  logic             ack_wr;
  logic [CNT_W-1:0] cfg_q;
  logic             arm;
  logic [CNT_W-1:0] arm_val;
  logic [CNT_W-1:0] count;
  logic             expire;

  always_comb begin
    op     = cdt_op_e'(req_op);
    is_wr  = req_valid && (op == OP_WR || op == OP_XCHG);
    cfg_wr = is_wr && req_addr == A_CFG;
    ack_wr = is_wr && req_addr == A_ACK;
  end

  cdt_cfg_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .xchg(op == OP_XCHG),
    .wdata(req_wdata), .mask(req_mask), .expire(expire),
    .cfg_q(cfg_q), .arm(arm), .arm_val(arm_val)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i), .cfg_wr(cfg_wr), .arm(arm),
    .arm_val(arm_val), .run(cfg_q[0]), .periodic(cfg_q[1]),
    .reload({cfg_q[CNT_W-1:2], 2'b00}), .count(count), .expire(expire)
  );

  cdt_irq u_irq (
    .clk(clk), .rst(rst), .set(expire), .clr(ack_wr), .irq_q(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rsp_rdata <= '0;
    else if (req_valid) begin
      case (req_addr)
        A_CFG:   rsp_rdata <= DATA_W'(cfg_q);
        A_REM:   rsp_rdata <= DATA_W'(count);
        A_ACK:   rsp_rdata <= '0;
        default: rsp_rdata <= ID_VAL;
      endcase
    end
  end

  p_id_read_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == A_ID) |=> rsp_rdata == ID_VAL);
  p_ack_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == A_ACK) |=> rsp_rdata == '0);
endmodule

// File: tb/cdt_top_tb.sv
module cdt_top_tb;
  localparam int ID = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [1:0]  req_addr = 2'd0;
  logic [63:0] req_wdata = '0;
  logic [63:0] req_mask = '0;
  logic [63:0] rsp_rdata;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cdt_top #(.DATA_W(64), .CNT_W(48), .CORE_ID(ID)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [1:0] addr,
                        input logic [63:0] wd, input logic [63:0] mk,
                        output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_mask = mk;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [63:0] wd);
    logic [63:0] d;
    access(2'd1, addr, wd, '0, d);
  endtask

  task automatic rd_chk(input logic [1:0] addr, input logic [63:0] exp, input string req);
    logic [63:0] d;
    access(2'd0, addr, '0, '0, d);
    check(req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1;
    end
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 irq", {63'd0, irq_o}, 64'd0);
    rd_chk(2'd0, 64'd0, "R1 cfg");
    rd_chk(2'd1, 64'd0, "R1 remaining");
    rd_chk(2'd3, 64'(ID), "R1 id");
  endtask

  task automatic t_load;
    wr(2'd0, 64'hABCD_0000_0000_0015);
    rd_chk(2'd0, 64'h15, "R2 cfg upper bits dropped");
    rd_chk(2'd1, 64'd20, "R2 count low bits zeroed");
  endtask

  task automatic t_countdown_freeze;
    ticks(5);
    rd_chk(2'd1, 64'd15, "R3 five ticks");
    wr(2'd0, 64'h14);
    rd_chk(2'd1, 64'd15, "R7 frozen after disarm");
    ticks(4);
    rd_chk(2'd1, 64'd15, "R7 ticks ignored while disarmed");
    check("R7 irq unchanged", {63'd0, irq_o}, 64'd0);
  endtask

  task automatic t_oneshot;
    wr(2'd0, 64'h9);
    ticks(8);
    rd_chk(2'd1, 64'd0, "R3 reached zero");
    check("R3 no expiry yet", {63'd0, irq_o}, 64'd0);
    ticks(1);
    check("R4 irq on expiry", {63'd0, irq_o}, 64'd1);
    rd_chk(2'd0, 64'h8, "R6 arm bit cleared");
    ticks(12);
    check("R4 irq held", {63'd0, irq_o}, 64'd1);
    rd_chk(2'd1, 64'd0, "R6 count stays zero");
    wr(2'd2, 64'd0);
    check("R8 ack drops irq", {63'd0, irq_o}, 64'd0);
    rd_chk(2'd2, 64'd0, "R8 ack reads zero");
    ticks(3);
    check("R6 no re-expiry", {63'd0, irq_o}, 64'd0);
  endtask

  task automatic t_periodic;
    wr(2'd0, 64'hB);
    ticks(9);
    check("R5 first period irq", {63'd0, irq_o}, 64'd1);
    rd_chk(2'd1, 64'd8, "R5 reloaded");
    rd_chk(2'd0, 64'hB, "R5 stays armed");
    wr(2'd2, 64'd0);
    ticks(9);
    check("R5 second period irq", {63'd0, irq_o}, 64'd1);
    rd_chk(2'd1, 64'd8, "R5 reloaded again");
    wr(2'd0, 64'h8);
    check("R7 disarm keeps irq", {63'd0, irq_o}, 64'd1);
    wr(2'd2, 64'd0);
  endtask

  task automatic t_zero;
    wr(2'd0, 64'h1);
    ticks(1);
    check("R3 zero count expires next tick", {63'd0, irq_o}, 64'd1);
    rd_chk(2'd0, 64'h0, "R6 zero one-shot disarmed");
    wr(2'd2, 64'd0);
  endtask

  task automatic t_race;
    wr(2'd0, 64'h1);
    @(negedge clk);
    tick_i = 1'b1; req_valid = 1'b1; req_op = 2'd1; req_addr = 2'd2; req_wdata = '0;
    @(negedge clk);
    tick_i = 1'b0; req_valid = 1'b0;
    check("R8 expiry beats ack", {63'd0, irq_o}, 64'd1);
    wr(2'd2, 64'd0);
    check("R8 later ack clears", {63'd0, irq_o}, 64'd0);
  endtask

  task automatic t_xchg;
    logic [63:0] d;
    wr(2'd0, 64'h10);
    access(2'd2, 2'd0, 64'h21, 64'hF, d);
    check("R9 exchange returns old", d, 64'h10);
    rd_chk(2'd0, 64'h11, "R9 merged value");
    rd_chk(2'd1, 64'd16, "R9 exchange arms");
  endtask

  task automatic t_ignored;
    wr(2'd1, 64'd5);
    rd_chk(2'd1, 64'd16, "R11 remaining write ignored");
    wr(2'd3, 64'd77);
    rd_chk(2'd3, 64'(ID), "R11 id write ignored");
    ticks(2);
    rd_chk(2'd1, 64'd14, "R10 live count");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_load;
    t_countdown_freeze;
    t_oneshot;
    t_periodic;
    t_zero;
    t_race;
    t_xchg;
    t_ignored;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule